// File: doc/BRIEF.md
# Two-Level Direct-Indexed Next-Hop Lookup

This block resolves the next hop for a stream of 32-bit IPv4 destination addresses using two directly indexed tables and no searching. The upper address bits index a first-level table of 16-bit entries. The top bit of an entry is a flag:
- When the flag is clear, the entry holds the next hop directly.
- When the flag is set, the entry holds a block number. That block number, together with the lowest address byte, selects one entry of a second-level table, and that entry holds the next hop.

Software expands the prefixes and fills both tables through two write ports. The block only performs the lookups.

Addresses enter under a valid/ready handshake. A result leaves, in order, a fixed two cycles later, and a new lookup can start every cycle. A low downstream ready freezes the pipeline.

The first-level index width `L1_BITS` is a parameter. The full IPv4 setting is 24. The default is 12 so that a default elaboration stays small. When `L1_BITS` is below 24, the address bits between the index and the low byte do not take part in the lookup. The number of second-level blocks is 2^`BLK_W`.

Top module: `route_lookup2`

## Requirements
- R1: When the first-level entry at index `addr_i[31 -: L1_BITS]` has bit 15 equal to 0, `nh_o` equals bits 14:0 of that entry.
- R2: When that entry has bit 15 equal to 1, its low `BLK_W` bits form a block number `b`. `nh_o` equals the second-level entry at index `b*256 + addr_i[7:0]`. Block-field bits above `BLK_W` are ignored.
- R3: Address bits `[31-L1_BITS:8]` do not affect the result. Two addresses that differ only in those bits return the same next hop.
- R4: While `ready_i` is 1, `ready_o` is 1, so one address can be accepted every cycle.
- R5: With `ready_i` held at 1, the result of an address accepted in cycle c appears on `out_valid_o`/`nh_o` in cycle c+2. This holds for both paths.
- R6: While `out_valid_o` is 1 and `ready_i` is 0, the output stays valid and `nh_o` holds its value in the next cycle. Every accepted address yields exactly one result, in acceptance order.
- R7: Whenever `out_valid_o` is 0, `ready_o` is 1.
- R8: A table write is seen by every lookup accepted in a later cycle. A first-level write does not affect a lookup accepted in the same cycle.
- R9: During and right after reset, `out_valid_o` is 0 and `ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Address present |
| addr_i | input | 32 | Destination address |
| ready_o | output | 1 | Address accepted this cycle when valid_i is 1 |
| out_valid_o | output | 1 | Result present |
| nh_o | output | 15 | Next hop |
| ready_i | input | 1 | Downstream takes the result |
| l1_we_i | input | 1 | First-level table write strobe |
| l1_waddr_i | input | L1_BITS | First-level write index |
| l1_wdata_i | input | 16 | First-level entry: bit 15 flag, bits 14:0 next hop or block |
| l2_we_i | input | 1 | Second-level table write strobe |
| l2_waddr_i | input | BLK_W+8 | Second-level write index (block*256 + low byte) |
| l2_wdata_i | input | 15 | Second-level next hop |

## Verification
An address accepted in cycle c has its result due in cycle c+2, provided downstream ready stays high. Stalled results are due in the first cycle after the one in which the output was held. The bench drives inputs on the falling edge and samples one time unit later. It records the acceptance cycle of each address together with the expected next hop, computed from a shadow copy of the tables. In phases without stalls, each result is compared both for its value and for arriving exactly two cycles after acceptance. In stall phases, the bench checks that a held output stays unchanged for the next cycle. Each shadow table is updated only after the same-cycle acceptance has been recorded, which is what the rule on write timing requires.

// File: rtl/rl_pkg.sv
package rl_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned ENT_W  = 16;
  localparam int unsigned NH_W   = 15;
  localparam int unsigned SUB_W  = 8;

  function automatic logic ent_is_ptr(input logic [ENT_W-1:0] e);
    return e[ENT_W-1];
  endfunction
endpackage

// File: rtl/rl_ram.sv
module rl_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // registered read; output holds while re_i is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/rl_l1_stage.sv
module rl_l1_stage import rl_pkg::*; #(
  parameter int unsigned L1_BITS = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  input  logic               valid_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [L1_BITS-1:0] waddr_i,
  input  logic [ENT_W-1:0]   wdata_i,
  output logic               s1_v_o,
  output logic [ENT_W-1:0]   s1_ent_o,
  output logic [SUB_W-1:0]   s1_low_o
);
  logic [L1_BITS-1:0] idx;
  assign idx = addr_i[ADDR_W-1 -: L1_BITS];

  rl_ram #(.AW(L1_BITS), .DW(ENT_W)) u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .waddr_i(waddr_i),
    .wdata_i(wdata_i),
    .re_i   (adv_i),
    .raddr_i(idx),
    .rdata_o(s1_ent_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_o   <= 1'b0;
      s1_low_o <= '0;
    end else if (adv_i) begin
      s1_v_o   <= valid_i;
      s1_low_o <= addr_i[SUB_W-1:0];
    end
  end
endmodule

// File: rtl/rl_l2_stage.sv
module rl_l2_stage import rl_pkg::*; #(
  parameter int unsigned BLK_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   adv_i,
  input  logic                   s1_v_i,
  input  logic [ENT_W-1:0]       s1_ent_i,
  input  logic [SUB_W-1:0]       s1_low_i,
  input  logic                   we_i,
  input  logic [BLK_W+SUB_W-1:0] waddr_i,
  input  logic [NH_W-1:0]        wdata_i,
  output logic                   out_v_o,
  output logic [NH_W-1:0]        nh_o
);
  localparam int unsigned AW = BLK_W + SUB_W;

  logic          ptr, rd_en;
  logic [AW-1:0] ridx;
  logic [NH_W-1:0] l2_q, nh_q;
  logic          ptr_q;

  assign ptr   = ent_is_ptr(s1_ent_i);
  assign rd_en = adv_i & s1_v_i & ptr;
  assign ridx  = {s1_ent_i[BLK_W-1:0], s1_low_i};

  rl_ram #(.AW(AW), .DW(NH_W)) u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .waddr_i(waddr_i),
    .wdata_i(wdata_i),
    .re_i   (rd_en),
    .raddr_i(ridx),
    .rdata_o(l2_q)
  );

  // direct hops ride alongside the second read to keep order and latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_o <= 1'b0;
      ptr_q   <= 1'b0;
      nh_q    <= '0;
    end else if (adv_i) begin
      out_v_o <= s1_v_i;
      ptr_q   <= ptr;
      nh_q    <= s1_ent_i[NH_W-1:0];
    end
  end

  assign nh_o = ptr_q ? l2_q : nh_q;
endmodule

// File: rtl/route_lookup2.sv
module route_lookup2 import rl_pkg::*; #(
  parameter int unsigned L1_BITS = 12,
  parameter int unsigned BLK_W   = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [ADDR_W-1:0]      addr_i,
  output logic                   ready_o,
  output logic                   out_valid_o,
  output logic [NH_W-1:0]        nh_o,
  input  logic                   ready_i,
  input  logic                   l1_we_i,
  input  logic [L1_BITS-1:0]     l1_waddr_i,
  input  logic [ENT_W-1:0]       l1_wdata_i,
  input  logic                   l2_we_i,
  input  logic [BLK_W+SUB_W-1:0] l2_waddr_i,
  input  logic [NH_W-1:0]        l2_wdata_i
);
  logic             s1_v, adv1, adv2;
  logic [ENT_W-1:0] s1_ent;
  logic [SUB_W-1:0] s1_low;

  assign adv2    = ~out_valid_o | ready_i;
  assign adv1    = ~s1_v | adv2;
  assign ready_o = adv1;

  rl_l1_stage #(.L1_BITS(L1_BITS)) u_l1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv1),
    .valid_i (valid_i),
    .addr_i  (addr_i),
    .we_i    (l1_we_i),
    .waddr_i (l1_waddr_i),
    .wdata_i (l1_wdata_i),
    .s1_v_o  (s1_v),
    .s1_ent_o(s1_ent),
    .s1_low_o(s1_low)
  );

  rl_l2_stage #(.BLK_W(BLK_W)) u_l2 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv2),
    .s1_v_i  (s1_v),
    .s1_ent_i(s1_ent),
    .s1_low_i(s1_low),
    .we_i    (l2_we_i),
    .waddr_i (l2_waddr_i),
    .wdata_i (l2_wdata_i),
    .out_v_o (out_valid_o),
    .nh_o    (nh_o)
  );
endmodule

// File: rtl/rl_chk.sv
module rl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        ready_o,
  input logic        ready_i,
  input logic        out_valid_o,
  input logic [14:0] nh_o
);
  logic [2:0] inflight_q;
  logic       acc, fire;

  assign acc  = valid_i & ready_o;
  assign fire = out_valid_o & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + {2'b0, acc} - {2'b0, fire};
  end

  a_r4_full_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> ready_o);

  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc ##1 ready_i |=> out_valid_o);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !ready_i) |=> (out_valid_o && $stable(nh_o)));

  a_r6_no_phantom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (inflight_q != 3'd0));

  a_r6_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= 3'd2);

  a_r7_ready_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> ready_o);
endmodule

bind route_lookup2 rl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .ready_o    (ready_o),
  .ready_i    (ready_i),
  .out_valid_o(out_valid_o),
  .nh_o       (nh_o)
);

// File: tb/sim_route_lookup2.sv
`timescale 1ns/1ps
module sim_route_lookup2;
  localparam int unsigned L1B = 8;
  localparam int unsigned BW  = 3;
  localparam int unsigned L1N = 1 << L1B;
  localparam int unsigned L2N = 1 << (BW + 8);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0, ready_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic ready_o, out_valid_o;
  logic [14:0] nh_o;
  logic l1_we_i = 1'b0, l2_we_i = 1'b0;
  logic [L1B-1:0] l1_waddr_i = '0;
  logic [15:0] l1_wdata_i = '0;
  logic [BW+7:0] l2_waddr_i = '0;
  logic [14:0] l2_wdata_i = '0;

  always #5 clk_i = ~clk_i;

  route_lookup2 #(.L1_BITS(L1B), .BLK_W(BW)) u0 (.*);

  logic [15:0] l1m [L1N];
  logic [14:0] l2m [L2N];
  int checks = 0, errors = 0, cyc = 0;
  bit strict = 1'b0;
  bit p1 = 0, p2 = 0;
  logic [L1B-1:0] p1a; logic [15:0] p1d;
  logic [BW+7:0]  p2a; logic [14:0] p2d;
  bit prev_hold = 0; logic [14:0] prev_nh = '0;
  logic [14:0] exp_q[$]; int acc_q[$]; string tag_q[$];

  function automatic logic [14:0] exp_nh(input logic [31:0] a);
    logic [15:0] e = l1m[a[31 -: L1B]];
    if (e[15]) return l2m[{e[BW-1:0], a[7:0]}];
    return e[14:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h cycle=%0d", req, act, expv, cyc);
    end
  endtask

  task automatic cycle(input bit v, input logic [31:0] a, input bit r, input string t = "");
    @(negedge clk_i);
    valid_i = v; addr_i = a; ready_i = r;
    l1_we_i = p1; l1_waddr_i = p1a; l1_wdata_i = p1d;
    l2_we_i = p2; l2_waddr_i = p2a; l2_wdata_i = p2d;
    #1;
    if (prev_hold) chk(out_valid_o && nh_o == prev_nh, "R6", {16'h0, out_valid_o, nh_o}, {16'h1, 1'b0, prev_nh});
    if (!out_valid_o) chk(ready_o, "R7", ready_o, 1);
    if (ready_i) chk(ready_o, "R4", ready_o, 1);
    if (out_valid_o && ready_i) begin
      if (exp_q.size() == 0) chk(0, "R6", nh_o, 0);
      else begin
        logic [14:0] e = exp_q.pop_front();
        int ac = acc_q.pop_front();
        string tg = tag_q.pop_front();
        chk(nh_o == e, tg, nh_o, e);
        if (strict) chk(cyc == ac + 2, "R5", cyc, ac + 2);
      end
    end
    if (valid_i && ready_o) begin
      exp_q.push_back(exp_nh(a));
      acc_q.push_back(cyc);
      if (t != "") tag_q.push_back(t);
      else tag_q.push_back(l1m[a[31 -: L1B]][15] ? "R2" : "R1");
    end
    prev_hold = out_valid_o && !ready_i;
    prev_nh = nh_o;
    if (p1) l1m[p1a] = p1d;
    if (p2) l2m[p2a] = p2d;
    p1 = 0; p2 = 0;
    cyc++;
  endtask

  task automatic wr1(input int i, input logic [15:0] d);
    p1 = 1; p1a = i[L1B-1:0]; p1d = d; cycle(0, '0, 1);
  endtask
  task automatic wr2(input int i, input logic [14:0] d);
    p2 = 1; p2a = i[BW+7:0]; p2d = d; cycle(0, '0, 1);
  endtask
  task automatic drain();
    for (int k = 0; k < 8; k++) cycle(0, '0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(!out_valid_o && ready_o, "R9", {out_valid_o, ready_o}, 2'b01);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!out_valid_o && ready_o, "R9", {out_valid_o, ready_o}, 2'b01);

    for (int i = 0; i < L1N; i++) wr1(i, 16'($urandom));
    for (int i = 0; i < L2N; i++) wr2(i, 15'($urandom));
    wr1(5, 16'h0123);
    wr1(6, 16'hFFFA);
    wr2({3'd2, 8'h9C}, 15'h5A5A);
    drain();

    strict = 1;
    cycle(1, 32'h05_0000_77, 1, "R1");
    cycle(1, 32'h06_0000_9C, 1, "R2");
    cycle(1, 32'h06_ABCD_9C, 1, "R3");
    cycle(1, 32'h05_FFFF_01, 1, "R3");
    drain();
    chk(exp_q.size() == 0, "R5", exp_q.size(), 0);

    for (int k = 0; k < 400; k++) cycle($urandom_range(0, 3) != 0, $urandom, 1);
    drain();

    strict = 0;
    for (int k = 0; k < 3000; k++) cycle($urandom_range(0, 1), $urandom, $urandom_range(0, 2) != 0);
    for (int k = 0; k < 20; k++) cycle(1, $urandom, 0);
    drain();
    chk(exp_q.size() == 0, "R6", exp_q.size(), 0);

    strict = 1;
    p1 = 1; p1a = 8'd9; p1d = 16'h0444;
    if (l1m[9] == 16'h0444) p1d = 16'h0555;
    cycle(1, 32'h09_0000_00, 1, "R8");
    cycle(1, 32'h09_0000_00, 1, "R8");
    p1 = 1; p1a = 8'd10; p1d = 16'h8005;
    cycle(0, '0, 1);
    p2 = 1; p2a = {3'd5, 8'h33}; p2d = 15'h1357;
    cycle(0, '0, 1);
    cycle(1, 32'h0A_0000_33, 1, "R8");
    drain();
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule